// File: doc/BRIEF.md
# Burst Column Sequencer

This block generates the column address stream for one synchronous DRAM read or write burst. It holds an 8-bit column, so a page has 256 words. A start command latches a first column, a burst length code and a wrap order, either linear or exclusive-OR. From the next cycle on, the block presents one column per accepted beat on a valid/ready output. The last beat of a fixed-length burst is flagged. A page-length burst runs on and wraps around the page until a command ends it.

Two commands can act on a burst in progress. A stop strobe ends the burst. A restart strobe supplies a new first column and keeps the length and wrap order already latched. Either command takes effect on the next clock edge, whatever beat the burst has reached. A start request that names an unsupported combination is refused. The refusal is reported by a one-cycle flag and does not disturb any burst in progress.

The output follows back-pressure rules. While `col_valid_o` is high and `col_ready_i` is low, the column and the beat position hold still. A beat is consumed only on a clock edge where both signals are high. Stop, restart and start act regardless of `col_ready_i`.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid_o`, `col_last_o` and `bad_req_o` are all low.
- R2: An accepted start makes `col_valid_o` high on the next cycle, with `col_o` equal to the start column (beat 0). Length codes are 0, 1, 2, 3 for 1, 2, 4, 8 beats and 4 for a full page; codes 5 to 7 are reserved.
- R3: When `ilv_i` is 0 (linear order), beat n shows the start column with its low log2(BL) bits replaced by (start + n) mod BL. The upper bits stay fixed.
- R4: When `ilv_i` is 1 (exclusive-OR order), beat n shows the start column with its low log2(BL) bits exclusive-ORed with n.
- R5: `col_last_o` is high only together with `col_valid_o`, and only on beat BL-1 of a fixed-length burst. Once that beat is consumed, `col_valid_o` goes low.
- R6: A full-page burst in linear order steps from column 255 to column 0. It never raises `col_last_o` and keeps running until it is stopped or replaced.
- R7: A start with a reserved length code, or with code 4 and `ilv_i` = 1, is refused. `bad_req_o` pulses high on the next cycle, and the burst state moves exactly as it would have without that start.
- R8: While `col_valid_o` is high and `col_ready_i` is low, `col_o` and the beat position stay unchanged.
- R9: A stop with no accepted start and no effective restart makes `col_valid_o` low on the next cycle.
- R10: A restart during a burst shows the restart column as beat 0 on the next cycle. It keeps the latched length and order. A restart while idle is ignored.
- R11: An accepted start wins over a restart in the same cycle. A start or restart wins over a stop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request strobe |
| start_col_i | input | 8 | First column for a start |
| len_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects exclusive-OR order, 0 selects linear order |
| restart_i | input | 1 | Restart strobe, used only during a burst |
| restart_col_i | input | 8 | First column for a restart |
| stop_i | input | 1 | Stop strobe |
| col_ready_i | input | 1 | Consumer accepts the current column |
| col_o | output | 8 | Current column |
| col_valid_o | output | 1 | Column is valid |
| col_last_o | output | 1 | Current column is the final beat |
| bad_req_o | output | 1 | One-cycle pulse for a refused start |

## Verification
A stop can land in the same cycle as a restart or a start, so the priority rule has to be judged directly. The bench raises stop together with a restart during a burst, and expects the new column as beat 0 and a complete burst after it. It raises a start together with a restart and expects the start's column and order to win. It also raises a refused start together with a stop during a page burst, and expects the refusal flag and an idle output on the following cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int LEN_W = 3;
  localparam logic [LEN_W-1:0] LEN_1    = 3'd0;
  localparam logic [LEN_W-1:0] LEN_2    = 3'd1;
  localparam logic [LEN_W-1:0] LEN_4    = 3'd2;
  localparam logic [LEN_W-1:0] LEN_8    = 3'd3;
  localparam logic [LEN_W-1:0] LEN_PAGE = 3'd4;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_W-1:0] len_code,
  input  logic             ilv,
  output logic [COL_W-1:0] wrap_mask,
  output logic             page,
  output logic             legal
);
  always_comb begin
    wrap_mask = '0;
    page      = 1'b0;
    legal     = 1'b1;
    unique case (len_code)
      LEN_1:    wrap_mask = '0;
      LEN_2:    wrap_mask = COL_W'(1);
      LEN_4:    wrap_mask = COL_W'(3);
      LEN_8:    wrap_mask = COL_W'(7);
      LEN_PAGE: begin
        wrap_mask = '1;
        page      = 1'b1;
        legal     = !ilv;
      end
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcs_col_form.sv
module bcs_col_form #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] lin_sum;
  assign lin_sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = wrap_mask[i] ? (ilv ? (base[i] ^ beat[i]) : lin_sum[i])
                                 : base[i];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ilv_i,
  input  logic             restart_i,
  input  logic [COL_W-1:0] restart_col_i,
  input  logic             stop_i,
  input  logic             col_ready_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_valid_o,
  output logic             col_last_o,
  output logic             bad_req_o
);
  localparam logic [COL_W-1:0] BEAT_ONE = COL_W'(1);

  logic             act_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             ilv_q, page_q, bad_q;

  logic [COL_W-1:0] req_mask;
  logic             req_page, req_legal;

  bcs_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code (len_i),
    .ilv      (ilv_i),
    .wrap_mask(req_mask),
    .page     (req_page),
    .legal    (req_legal)
  );

  bcs_col_form #(.COL_W(COL_W)) u_form (
    .base     (base_q),
    .beat     (beat_q),
    .wrap_mask(mask_q),
    .ilv      (ilv_q),
    .col      (col_o)
  );

  logic at_last, take, load_start, load_restart;
  assign at_last      = act_q && !page_q && (beat_q == mask_q);
  assign take         = act_q && col_ready_i;
  assign load_start   = start_i && req_legal;
  assign load_restart = restart_i && act_q && !load_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      page_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= start_i && !req_legal;
      if (load_start) begin
        act_q  <= 1'b1;
        base_q <= start_col_i;
        beat_q <= '0;
        mask_q <= req_mask;
        ilv_q  <= ilv_i;
        page_q <= req_page;
      end else if (load_restart) begin
        base_q <= restart_col_i;
        beat_q <= '0;
      end else if (stop_i) begin
        act_q <= 1'b0;
      end else if (take) begin
        if (at_last) act_q  <= 1'b0;
        else         beat_q <= beat_q + BEAT_ONE;
      end
    end
  end

  assign col_valid_o = act_q;
  assign col_last_o  = at_last;
  assign bad_req_o   = bad_q;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [LEN_W-1:0] len_i,
  input logic             ilv_i,
  input logic             restart_i,
  input logic             stop_i,
  input logic             col_ready_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_valid_o,
  input logic             col_last_o,
  input logic             bad_req_o
);
  logic ok_req, quiet;
  assign ok_req = (len_i < LEN_PAGE) || (len_i == LEN_PAGE && !ilv_i);
  assign quiet  = !start_i && !restart_i && !stop_i;

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ok_req) |=> (col_valid_o && col_o == $past(start_col_i)));

  // R7
  refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ok_req) |=> bad_req_o);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i && !restart_i) |=> !col_valid_o);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_o && !col_ready_i && quiet) |=> (col_valid_o && $stable(col_o)));

  // R5
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last_o |-> col_valid_o);

  // R5
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_o && col_ready_i && col_last_o && quiet) |=> !col_valid_o);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) u_bcs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .start_col_i(start_col_i),
  .len_i      (len_i),
  .ilv_i      (ilv_i),
  .restart_i  (restart_i),
  .stop_i     (stop_i),
  .col_ready_i(col_ready_i),
  .col_o      (col_o),
  .col_valid_o(col_valid_o),
  .col_last_o (col_last_o),
  .bad_req_o  (bad_req_o)
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_i = '0;
  logic       ilv_i = 1'b0;
  logic       restart_i = 1'b0;
  logic [7:0] restart_col_i = '0;
  logic       stop_i = 1'b0;
  logic       col_ready_i = 1'b1;
  logic [7:0] col_o;
  logic       col_valid_o, col_last_o, bad_req_o;

  int n_chk = 0;
  int n_fail = 0;

  burst_col_seq #(.COL_W(8)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_i(len_i), .ilv_i(ilv_i), .restart_i(restart_i),
    .restart_col_i(restart_col_i), .stop_i(stop_i), .col_ready_i(col_ready_i),
    .col_o(col_o), .col_valid_o(col_valid_o), .col_last_o(col_last_o),
    .bad_req_o(bad_req_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_col(input int b, input int n, input int bl, input bit il);
    int m = bl - 1;
    if (il) return (b & ~m & 255) | ((b ^ n) & m);
    return (b & ~m & 255) | ((b + n) & m);
  endfunction

  // Drive a one-cycle command; on return the cycle after it is visible.
  task automatic cmd(input bit st, input int col, input int code, input bit il,
                     input bit rs, input int rcol, input bit sp);
    @(negedge clk);
    start_i = st; start_col_i = 8'(col); len_i = 3'(code); ilv_i = il;
    restart_i = rs; restart_col_i = 8'(rcol); stop_i = sp;
    @(negedge clk);
    start_i = 0; restart_i = 0; stop_i = 0;
  endtask

  // Walk a fixed burst from beat 0 (visible now) to its end.
  task automatic walk(input string tag, input int b, input int bl, input bit il);
    for (int n = 0; n < bl; n++) begin
      chk({tag, " col"}, col_o, exp_col(b, n, bl, il));
      chk("R5 last", col_last_o, (n == bl - 1));
      @(negedge clk);
    end
    chk("R5 end", col_valid_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 valid", col_valid_o, 0);
    chk("R1 last", col_last_o, 0);
    chk("R1 bad", bad_req_o, 0);
  endtask

  task automatic t_linear;
    cmd(1, 8'h37, 3, 0, 0, 0, 0);
    chk("R2 valid", col_valid_o, 1);
    walk("R3", 8'h37, 8, 0);
    cmd(1, 8'h9E, 1, 0, 0, 0, 0);
    walk("R3", 8'h9E, 2, 0);
    cmd(1, 8'h5A, 0, 0, 0, 0, 0);
    walk("R3", 8'h5A, 1, 0);
  endtask

  task automatic t_xor;
    cmd(1, 8'hC6, 3, 1, 0, 0, 0);
    walk("R4", 8'hC6, 8, 1);
    cmd(1, 8'h13, 2, 1, 0, 0, 0);
    walk("R4", 8'h13, 4, 1);
  endtask

  task automatic t_page;
    cmd(1, 8'hFA, 4, 0, 0, 0, 0);
    for (int n = 0; n < 12; n++) begin
      chk("R6 col", col_o, (8'hFA + n) & 255);
      chk("R6 last", col_last_o, 0);
      @(negedge clk);
    end
    cmd(0, 0, 0, 0, 0, 0, 1);
    chk("R9 stop", col_valid_o, 0);
  endtask

  task automatic t_refuse;
    cmd(1, 8'h20, 4, 1, 0, 0, 0);
    chk("R7 bad", bad_req_o, 1);
    chk("R7 idle", col_valid_o, 0);
    cmd(1, 8'h20, 6, 0, 0, 0, 0);
    chk("R7 reserved", bad_req_o, 1);
    chk("R7 idle2", col_valid_o, 0);
    cmd(1, 8'h00, 3, 0, 0, 0, 0);   // beat 0
    cmd(1, 8'h55, 5, 0, 0, 0, 0);   // refused during beat 1
    chk("R7 bad busy", bad_req_o, 1);
    chk("R7 keeps burst", col_o, 8'h02);
    @(negedge clk);
    chk("R7 pulse", bad_req_o, 0);
    chk("R7 next", col_o, 8'h03);
    cmd(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_stall;
    cmd(1, 8'h41, 2, 0, 0, 0, 0);
    col_ready_i = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 hold col", col_o, 8'h41);
      chk("R8 hold valid", col_valid_o, 1);
    end
    col_ready_i = 1;
    @(negedge clk);
    chk("R8 resume", col_o, 8'h42);
    @(negedge clk);
    chk("R8 col", col_o, 8'h43);
    @(negedge clk);
    chk("R8 wrap", col_o, 8'h40);
    chk("R5 last", col_last_o, 1);
    @(negedge clk);
    chk("R5 done", col_valid_o, 0);
  endtask

  task automatic t_restart;
    cmd(1, 8'h10, 3, 0, 0, 0, 0);
    @(negedge clk);
    chk("R10 beat1", col_o, 8'h11);
    cmd(0, 0, 0, 0, 1, 8'h2D, 0);
    walk("R10", 8'h2D, 8, 0);
    cmd(0, 0, 0, 0, 1, 8'h66, 0);
    chk("R10 idle ignore", col_valid_o, 0);
  endtask

  task automatic t_collide;
    cmd(1, 8'h80, 2, 0, 0, 0, 0);
    cmd(0, 0, 0, 0, 1, 8'h93, 1);
    chk("R11 restart over stop", col_valid_o, 1);
    walk("R11", 8'h93, 4, 0);
    cmd(1, 8'h40, 3, 0, 0, 0, 0);
    cmd(1, 8'h05, 1, 1, 1, 8'h77, 0);
    walk("R11 start over restart", 8'h05, 2, 1);
    cmd(1, 8'h00, 4, 0, 0, 0, 0);
    cmd(1, 8'h30, 4, 1, 0, 0, 1);
    chk("R11 refused+stop bad", bad_req_o, 1);
    chk("R11 refused+stop idle", col_valid_o, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_linear;
    t_xor;
    t_page;
    t_refuse;
    t_stall;
    t_restart;
    t_collide;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule